// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register file of one channel of a descriptor-driven copy/XOR engine. Software reaches it over a plain 32-bit register bus with a byte address, a write strobe and combinational read data. It holds the channel's control word (run enable and an append request), a status word with a busy indication and sticky completion and error flags, the address of the descriptor the engine is working on, and the next-descriptor pointer that software loads before starting the channel.

Toward the data mover it provides a run-enable level and two one-cycle commands. A start command asks the engine to begin at the next-descriptor pointer. A resume command asks it to reread the link field of the last descriptor it finished, so descriptors added to the tail are picked up. The data mover reports back with one-cycle pulses: the descriptor fetch (with its address), the end of each transfer, the end of the chain and error events. Each pulse may carry an interrupt-enable bit from the descriptor. The block folds the sticky flags into three interrupt lines: end-of-transfer, end-of-chain and error.

An append request arriving while the channel is still working is held. It is issued as a resume on the cycle after the chain ends, so a tail link written late in a chain is not lost.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads 0. `run_en_o`, `start_o`, `resume_o`, `next_desc_o` and all three interrupt outputs are 0.
- R2: The byte offsets are: control 0x00, status 0x04, current descriptor 0x08, next descriptor 0x24. Any other offset reads 0 and writes to it are dropped. In the control word, bit 0 is the run enable and bit 1 is the append request that is still pending.
- R3: Writing control bit 0 = 1 while the channel is disabled raises `start_o` for exactly one cycle, starting the cycle after the write, and sets busy (status bit 13). Writing bit 0 = 1 while already enabled issues no start.
- R4: Writing control bit 0 = 0 drops `run_en_o`, clears busy and discards any pending append. No start or resume follows.
- R5: Writing control with both bits 1 and 0 set, while enabled and idle, raises `resume_o` for one cycle, starting the cycle after the write, and sets busy. The append bit is self-clearing and reads back 0.
- R6: An append written while busy issues no resume and reads back as control bit 1 = 1. On the chain-end pulse, `resume_o` rises for one cycle, starting the cycle after the pulse. Busy stays set and the pending bit clears.
- R7: An append written while the channel is disabled is ignored. A write of 0x3 to a disabled channel issues only a start.
- R8: The current-descriptor register takes `fetch_addr_i` on each `fetch_i` pulse and is read-only over the bus.
- R9: The next-descriptor register is written and read at 0x24, and its value drives `next_desc_o`.
- R10: The status flags are sticky: end-of-transfer is bit 12 and end-of-chain is bit 11. Writing 1 to a flag's bit clears it and writing 0 leaves it unchanged. Busy cannot be written. An event in the same cycle as a clear wins.
- R11: Bit `err_i[k]` sets status bit 3, 4, 5 or 9 for k = 0, 1, 2, 3 (master abort, target abort, memory-controller abort, parity). Any error clears busy and discards a pending append. `irq_err_o` is high while any error flag is set.
- R12: `irq_eot_o` and `irq_eoc_o` are high only while their flag is set by an event that arrived with `evt_irq_en_i` = 1. An event with the enable at 0 sets the flag without raising the line.
- R13: A chain-end pulse with no pending append clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| run_en_o | output | 1 | Channel run enable |
| start_o | output | 1 | One-cycle command: begin at the next-descriptor pointer |
| resume_o | output | 1 | One-cycle command: reread the link of the last descriptor |
| next_desc_o | output | DESC_AW | Next-descriptor pointer |
| fetch_i | input | 1 | Engine starts fetching a descriptor |
| fetch_addr_i | input | DESC_AW | Address of that descriptor |
| xfer_done_i | input | 1 | One transfer completed |
| chain_end_i | input | 1 | Chain ended (null link reached) |
| evt_irq_en_i | input | 1 | Interrupt enable of the descriptor behind this cycle's completion event |
| err_i | input | 4 | Error pulses: master abort, target abort, memory-controller abort, parity |
| irq_eot_o | output | 1 | End-of-transfer interrupt |
| irq_eoc_o | output | 1 | End-of-chain interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The bench uses the default values: an 8-bit offset, 32-bit data and 32-bit descriptor addresses. With these, every mapped offset and an unmapped one (0x28) can be reached, and a full-width pointer pattern can be written and read back. Full-width patterns catch truncated or shifted bits in the current and next descriptor registers. The scenarios place an append before, during and after a busy chain. They also fire a completion event in the same cycle as its clear, and fire errors both singly and in pairs so that each error maps to its own status bit.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int NUM_ERR  = 4;
  localparam int BUSY_BIT = 13;
  localparam int EOT_BIT  = 12;
  localparam int EOC_BIT  = 11;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_CUR  = 'h08;
  localparam int OFF_NEXT = 'h24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CUR,
    SEL_NEXT
  } reg_sel_e;

  // status bit that holds error source idx
  function automatic int err_bit_pos(input int idx);
    case (idx)
      0:       return 3;
      1:       return 4;
      2:       return 5;
      default: return 9;
    endcase
  endfunction

  // sticky flag update: a set beats a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic reg_sel_e decode_offset(input int unsigned off);
    case (off)
      OFF_CTRL: return SEL_CTRL;
      OFF_STAT: return SEL_STAT;
      OFF_CUR:  return SEL_CUR;
      OFF_NEXT: return SEL_NEXT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_next
);
  always_comb begin
    sel     = decode_offset(int'(unsigned'(addr)));
    wr_ctrl = wr && (sel == SEL_CTRL);
    wr_stat = wr && (sel == SEL_STAT);
    wr_next = wr && (sel == SEL_NEXT);
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wd_en,
  input  logic wd_append,
  input  logic chain_end,
  input  logic err_any,
  output logic en_q,
  output logic busy_q,
  output logic pend_q,
  output logic start_o,
  output logic resume_o
);
  logic en_n, busy_n, pend_n, start_n, resume_n;

  always_comb begin
    en_n     = en_q;
    busy_n   = busy_q;
    pend_n   = pend_q;
    start_n  = 1'b0;
    resume_n = 1'b0;
    if (chain_end) begin
      if (pend_q) begin
        resume_n = 1'b1;
        pend_n   = 1'b0;
      end else begin
        busy_n = 1'b0;
      end
    end
    if (err_any) begin
      busy_n   = 1'b0;
      pend_n   = 1'b0;
      resume_n = 1'b0;
    end
    if (wr_ctrl) begin
      en_n = wd_en;
      if (!wd_en) begin
        busy_n   = 1'b0;
        pend_n   = 1'b0;
        resume_n = 1'b0;
      end else if (!en_q) begin
        start_n  = 1'b1;
        busy_n   = 1'b1;
        pend_n   = 1'b0;
        resume_n = 1'b0;
      end else if (wd_append) begin
        if (busy_n) begin
          pend_n = 1'b1;
        end else begin
          resume_n = 1'b1;
          busy_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      start_o  <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      en_q     <= en_n;
      busy_q   <= busy_n;
      pend_q   <= pend_n;
      start_o  <= start_n;
      resume_o <= resume_n;
    end
  end

  // R3: the two engine commands never overlap
  a_r3_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && resume_o));
  // R4: no command leaves a disabled channel
  a_r4_cmd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o || resume_o) |-> en_q);
  // R6: a held append exists only on a running, enabled channel
  a_r6_pend_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (busy_q && en_q));
  // R11: an error leaves the channel idle
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && !wr_ctrl) |=> (!busy_q && !pend_q));
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_eot,
  input  logic               set_eoc,
  input  logic               irq_en,
  input  logic [NUM_ERR-1:0] set_err,
  input  logic               clr_eot,
  input  logic               clr_eoc,
  input  logic [NUM_ERR-1:0] clr_err,
  output logic               eot_q,
  output logic               eoc_q,
  output logic [NUM_ERR-1:0] err_q,
  output logic               irq_eot_o,
  output logic               irq_eoc_o,
  output logic               irq_err_o
);
  logic eot_arm_q, eoc_arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eot_q     <= 1'b0;
      eoc_q     <= 1'b0;
      eot_arm_q <= 1'b0;
      eoc_arm_q <= 1'b0;
    end else begin
      eot_q     <= sticky_next(eot_q, set_eot, clr_eot);
      eoc_q     <= sticky_next(eoc_q, set_eoc, clr_eoc);
      eot_arm_q <= sticky_next(eot_arm_q, set_eot & irq_en, clr_eot);
      eoc_arm_q <= sticky_next(eoc_arm_q, set_eoc & irq_en, clr_eoc);
    end
  end

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[k] <= 1'b0;
      else        err_q[k] <= sticky_next(err_q[k], set_err[k], clr_err[k]);
    end
  end

  assign irq_eot_o = eot_q & eot_arm_q;
  assign irq_eoc_o = eoc_q & eoc_arm_q;
  assign irq_err_o = |err_q;

  // R10: a flag persists until cleared
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_q && !clr_eot) |=> eot_q);
  // R10: write-one clears when no event competes
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eoc && !set_eoc) |=> !eoc_q);
  // R12: completion interrupt rises only after an enabled event
  a_r12_eot_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eot_o) |-> $past(set_eot && irq_en));
  a_r12_eoc_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_eoc_o) |-> $past(set_eoc && irq_en));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int DESC_AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               run_en_o,
  output logic               start_o,
  output logic               resume_o,
  output logic [DESC_AW-1:0] next_desc_o,
  input  logic               fetch_i,
  input  logic [DESC_AW-1:0] fetch_addr_i,
  input  logic               xfer_done_i,
  input  logic               chain_end_i,
  input  logic               evt_irq_en_i,
  input  logic [NUM_ERR-1:0] err_i,
  output logic               irq_eot_o,
  output logic               irq_eoc_o,
  output logic               irq_err_o
);
  localparam int CTRL_W = 2;

  reg_sel_e           sel;
  logic               wr_ctrl, wr_stat, wr_next;
  logic               en_q, busy_q, pend_q;
  logic               eot_q, eoc_q;
  logic [NUM_ERR-1:0] err_q, clr_err;
  logic [DESC_AW-1:0] cur_q, next_q;
  logic [DATA_W-1:0]  stat_word;
  logic               err_any;

  assign err_any = |err_i;

  dma_chan_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .sel     (sel),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat),
    .wr_next (wr_next)
  );

  dma_chan_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wd_en     (bus_wdata[0]),
    .wd_append (bus_wdata[1]),
    .chain_end (chain_end_i),
    .err_any   (err_any),
    .en_q      (en_q),
    .busy_q    (busy_q),
    .pend_q    (pend_q),
    .start_o   (start_o),
    .resume_o  (resume_o)
  );

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_clr
    localparam int P = err_bit_pos(k);
    assign clr_err[k] = wr_stat & bus_wdata[P];
  end

  dma_chan_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_eot   (xfer_done_i),
    .set_eoc   (chain_end_i),
    .irq_en    (evt_irq_en_i),
    .set_err   (err_i),
    .clr_eot   (wr_stat & bus_wdata[EOT_BIT]),
    .clr_eoc   (wr_stat & bus_wdata[EOC_BIT]),
    .clr_err   (clr_err),
    .eot_q     (eot_q),
    .eoc_q     (eoc_q),
    .err_q     (err_q),
    .irq_eot_o (irq_eot_o),
    .irq_eoc_o (irq_eoc_o),
    .irq_err_o (irq_err_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      next_q <= '0;
    end else begin
      if (fetch_i) cur_q  <= fetch_addr_i;
      if (wr_next) next_q <= bus_wdata[DESC_AW-1:0];
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_BIT] = busy_q;
    stat_word[EOT_BIT]  = eot_q;
    stat_word[EOC_BIT]  = eoc_q;
    for (int k = 0; k < NUM_ERR; k++) stat_word[err_bit_pos(k)] = err_q[k];
  end

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata = DATA_W'({pend_q, en_q});
      SEL_STAT: bus_rdata = stat_word;
      SEL_CUR:  bus_rdata = DATA_W'(cur_q);
      SEL_NEXT: bus_rdata = DATA_W'(next_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign run_en_o    = en_q;
  assign next_desc_o = next_q;

  // R8: the current pointer follows each fetch
  a_r8_cur_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_i |=> (cur_q == $past(fetch_addr_i)));
  // R8: bus writes never alter the current pointer
  a_r8_cur_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_i |=> $stable(cur_q));
  // R9: the next pointer changes only through its own write
  a_r9_next_only_written: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_next |=> $stable(next_desc_o));
  initial begin
    a_r2_ctrl_fits: assert (CTRL_W <= DATA_W && BUSY_BIT < DATA_W && DESC_AW <= DATA_W);
  end
endmodule

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        run_en_o, start_o, resume_o;
  logic [31:0] next_desc_o;
  logic        fetch_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        xfer_done_i = 1'b0, chain_end_i = 1'b0, evt_irq_en_i = 1'b0;
  logic [3:0]  err_i = '0;
  logic        irq_eot_o, irq_eoc_o, irq_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] ST_BUSY = 32'h2000, ST_EOT = 32'h1000, ST_EOC = 32'h0800;

  always #2 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en_o(run_en_o),
    .start_o(start_o), .resume_o(resume_o), .next_desc_o(next_desc_o),
    .fetch_i(fetch_i), .fetch_addr_i(fetch_addr_i), .xfer_done_i(xfer_done_i),
    .chain_end_i(chain_end_i), .evt_irq_en_i(evt_irq_en_i), .err_i(err_i),
    .irq_eot_o(irq_eot_o), .irq_eoc_o(irq_eoc_o), .irq_err_o(irq_err_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic evt(input logic fe, input logic xd, input logic ce, input logic ie,
                     input logic [3:0] er);
    @(negedge clk);
    fetch_i = fe; xfer_done_i = xd; chain_end_i = ce; evt_irq_en_i = ie; err_i = er;
    @(negedge clk);
    fetch_i = 1'b0; xfer_done_i = 1'b0; chain_end_i = 1'b0; evt_irq_en_i = 1'b0; err_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 status", d, 0);
    rd(8'h08, d); check("R1 cur", d, 0);
    rd(8'h24, d); check("R1 next", d, 0);
    check("R1 outputs", {run_en_o, start_o, resume_o, irq_eot_o, irq_eoc_o, irq_err_o}, 0);
  endtask

  task automatic t_next_ptr;
    logic [31:0] d;
    wr(8'h24, 32'hA5C3_0F40);
    rd(8'h24, d); check("R9 next readback", d, 32'hA5C3_0F40);
    check("R9 next_desc_o", next_desc_o, 32'hA5C3_0F40);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, d); check("R2 unmapped reads 0", d, 0);
    rd(8'h24, d); check("R2 unmapped write dropped", d, 32'hA5C3_0F40);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(8'h00, 32'h1);
    check("R3 start pulse", {start_o, resume_o, run_en_o}, 3'b101);
    @(negedge clk);
    check("R3 start one cycle", start_o, 0);
    rd(8'h04, d); check("R3 busy set", d, ST_BUSY);
    wr(8'h00, 32'h1);
    check("R3 no restart when enabled", start_o, 0);
  endtask

  task automatic t_fetch;
    logic [31:0] d;
    fetch_addr_i = 32'h5A3C_96E0;
    evt(1'b1, 0, 0, 0, 4'h0);
    rd(8'h08, d); check("R8 cur follows fetch", d, 32'h5A3C_96E0);
    wr(8'h08, 32'h1234_5678);
    rd(8'h08, d); check("R8 cur read-only", d, 32'h5A3C_96E0);
  endtask

  task automatic t_append_busy;
    logic [31:0] d;
    wr(8'h00, 32'h3);
    check("R6 no resume while busy", resume_o, 0);
    rd(8'h00, d); check("R6 append held", d, 32'h3);
    evt(0, 0, 1'b1, 1'b1, 4'h0);
    check("R6 resume after chain end", resume_o, 1);
    rd(8'h04, d); check("R6 busy kept, eoc set", d, ST_BUSY | ST_EOC);
    rd(8'h00, d); check("R6 pending cleared", d, 32'h1);
    check("R12 eoc irq enabled", irq_eoc_o, 1);
    wr(8'h04, 32'h0);
    rd(8'h04, d); check("R10 write 0 keeps flags", d, ST_BUSY | ST_EOC);
    wr(8'h04, ST_EOC | ST_BUSY);
    rd(8'h04, d); check("R10 w1c eoc, busy read-only", d, ST_BUSY);
    check("R12 eoc irq drops", irq_eoc_o, 0);
  endtask

  task automatic t_xfer;
    logic [31:0] d;
    evt(0, 1'b1, 0, 1'b0, 4'h0);
    rd(8'h04, d); check("R10 eot sticky", d, ST_BUSY | ST_EOT);
    check("R12 eot irq masked", irq_eot_o, 0);
    wr(8'h04, ST_EOT);
    evt(0, 1'b1, 0, 1'b1, 4'h0);
    check("R12 eot irq enabled", irq_eot_o, 1);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = ST_EOT; bus_wr = 1'b1; xfer_done_i = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done_i = 1'b0;
    rd(8'h04, d); check("R10 event beats clear", d, ST_BUSY | ST_EOT);
    wr(8'h04, ST_EOT);
    rd(8'h04, d); check("R10 eot cleared", d, ST_BUSY);
  endtask

  task automatic t_chain_idle;
    logic [31:0] d;
    evt(0, 0, 1'b1, 1'b0, 4'h0);
    check("R13 no resume", resume_o, 0);
    rd(8'h04, d); check("R13 busy clears", d, ST_EOC);
    check("R12 eoc irq masked", irq_eoc_o, 0);
    wr(8'h04, ST_EOC);
  endtask

  task automatic t_append_idle;
    logic [31:0] d;
    wr(8'h00, 32'h3);
    check("R5 resume on idle append", {start_o, resume_o}, 2'b01);
    rd(8'h04, d); check("R5 busy after resume", d, ST_BUSY);
    rd(8'h00, d); check("R5 append self-clears", d, 32'h1);
  endtask

  task automatic t_error;
    logic [31:0] d;
    wr(8'h00, 32'h3);
    rd(8'h00, d); check("R11 pending before error", d, 32'h3);
    evt(0, 0, 0, 0, 4'b1001);
    check("R11 err irq", irq_err_o, 1);
    rd(8'h04, d); check("R11 parity+master abort bits", d, 32'h0208);
    rd(8'h00, d); check("R11 error drops pending", d, 32'h1);
    wr(8'h04, 32'h0200);
    rd(8'h04, d); check("R11 clear parity only", d, 32'h0008);
    check("R11 err irq holds", irq_err_o, 1);
    wr(8'h04, 32'h0008);
    check("R11 err irq clears", irq_err_o, 0);
    evt(0, 0, 0, 0, 4'b0110);
    rd(8'h04, d); check("R11 target+mcu abort bits", d, 32'h0030);
    wr(8'h04, 32'h0030);
    rd(8'h04, d); check("R11 all cleared", d, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(8'h00, 32'h3);
    wr(8'h00, 32'h3);
    rd(8'h00, d); check("R4 pending set before disable", d, 32'h3);
    wr(8'h00, 32'h0);
    check("R4 run enable drops", {run_en_o, start_o, resume_o}, 3'b000);
    rd(8'h00, d); check("R4 pending discarded", d, 0);
    rd(8'h04, d); check("R4 busy cleared", d, 0);
    wr(8'h00, 32'h2);
    check("R7 append while disabled ignored", {start_o, resume_o}, 2'b00);
    rd(8'h00, d); check("R7 ctrl stays 0", d, 0);
    wr(8'h00, 32'h3);
    check("R7 start only from disabled", {start_o, resume_o}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_next_ptr;
    t_enable;
    t_fetch;
    t_append_busy;
    t_xfer;
    t_chain_idle;
    t_append_idle;
    t_error;
    t_disable;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule